// File: doc/BRIEF.md
# Configurable Three-Stage Decimation Chain

This block sits behind a noise-shaping modulator and reduces its sample stream to a lower output rate. Each modulator sample arrives as a signed word qualified by an enable. The chain has three cascaded decimating FIR stages. The first stage always keeps one sample in four. The second stage keeps one in 2, 4, 8, 16 or 32, or can be bypassed. The third stage always keeps one in two.

A configuration write picks the tap point the output is taken from: the raw modulator word, stage 1, stage 2 or stage 3. The same write sets the stage-2 ratio and whether stage 2 is bypassed. The output rate is therefore the input rate divided by the product of the ratios of the active stages.

Every stage is a 7-tap symmetric FIR with the fixed weights 1,2,3,4,3,2,1. Its sum is divided by 16 with an arithmetic right shift, so DC gain is unity and the word width never grows. A data-valid flag stays low while the pipeline fills. It rises once a number of output words set by the configuration has been discarded. A configuration write flushes all filter history and restarts that count.

Top module: `decim_chain`

## Requirements
- R1: While reset is high and in the cycle after it, `out_stb` and `out_valid` are 0. The configuration then defaults to tap 3, stage 2 active, stage-2 select code 4.
- R2: With tap code 0, each sample taken with `in_en` appears on `out_data`, sign-extended to 24 bits, with `out_stb` high one cycle later.
- R3: Each stage keeps a 7-sample window, newest first, that is all zero after reset or a configuration write. On every Rth accepted input it emits floor((1·w0+2·w1+3·w2+4·w3+3·w4+2·w5+1·w6)/16), where w0 is the sample just accepted. A full-scale input does not overflow.
- R4: With tap code 1, the output is stage 1, which emits one word per 4 accepted samples and never strobes in two consecutive cycles.
- R5: Stage-2 select codes 0, 1, 2, 3 and 4 give ratios 2, 4, 8, 16 and 32; codes 5 to 7 also give 32. With tap code 2, the output is stage 2 fed by stage 1.
- R6: With the stage-2 bypass bit set, tap code 2 gives the stage-1 stream, and tap code 3 feeds stage 1 directly into stage 3.
- R7: With tap code 3, stage 3 decimates the stream arriving from stage 2 (or stage 1 when bypassed) by 2.
- R8: The number of output words after a configuration write equals the number of accepted samples divided (rounding down) by the product of the active ratios. With any filter stage active, `out_stb` is never high in two consecutive cycles.
- R9: After reset or a configuration write, `out_valid` is 0 for the first 4·S output words and 1 from word 4·S on. S is the number of active filter stages: 0 for tap 0, 1 for tap 1, 1 or 2 for tap 2, 2 or 3 for tap 3, one fewer when stage 2 is bypassed. Once high, `out_valid` stays high until the next write or reset.
- R10: A configuration write clears all filter windows and pending words. It drops any sample presented in the same cycle, and the cycle after it shows `out_stb` = 0 and `out_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tap | input | 2 | Tap point: 0 raw, 1 stage 1, 2 stage 2, 3 stage 3 |
| cfg_s2_bypass | input | 1 | 1 bypasses stage 2 |
| cfg_s2_sel | input | 3 | Stage-2 ratio select code |
| in_en | input | 1 | Input sample enable |
| in_data | input | 16 | Signed modulator sample |
| out_stb | output | 1 | Output word strobe |
| out_data | output | 24 | Signed output word |
| out_valid | output | 1 | Pipeline filled; current and later words valid |

## Verification
The raw path answers one cycle after the sample. A filtered word appears one cycle after the sample that completes a stage's decimation group, plus one cycle for each further active stage, so tap 3 answers four cycles after its last contributing sample. The effect of a configuration write shows in the very next cycle. The driver pushes each predicted word into a queue as it presents the sample. The monitor pops and compares 5 ns after every rising edge, so it always sees settled outputs. After each burst the bench idles eight cycles, which exceeds the deepest latency, and then checks that the queue is empty and that the word count matches the rate formula.

// File: rtl/decim_pkg.sv
package decim_pkg;

  localparam int NTAPS      = 7;
  localparam int COEF_SHIFT = 4;

  typedef enum logic [1:0] {
    TAP_RAW = 2'd0,
    TAP_S1  = 2'd1,
    TAP_S2  = 2'd2,
    TAP_S3  = 2'd3
  } tap_e;

  typedef struct packed {
    tap_e       tap;
    logic       s2_bypass;
    logic [2:0] s2_sel;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{tap: TAP_S3, s2_bypass: 1'b0, s2_sel: 3'd4};

  // triangular weights 1..4..1, summing to 2**COEF_SHIFT for 7 taps
  function automatic int coef(input int k);
    int m;
    m = (k < NTAPS / 2) ? k : NTAPS - 1 - k;
    return m + 1;
  endfunction

  function automatic logic [2:0] s2_log2(input logic [2:0] sel);
    return (sel >= 3'd4) ? 3'd5 : sel + 3'd1;
  endfunction

endpackage

// File: rtl/fir_decim.sv
module fir_decim
  import decim_pkg::*;
#(
  parameter int W  = 16,
  parameter int LW = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                in_en,
  input  logic signed [W-1:0] in_data,
  input  logic [LW-1:0]       ratio_log2,
  output logic                out_en,
  output logic signed [W-1:0] out_data
);

  localparam int AW = W + COEF_SHIFT + 1;
  localparam int CW = (1 << LW) - 1;

  logic signed [W-1:0]  hist [NTAPS-1];
  logic signed [AW-1:0] win  [NTAPS];
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] shifted;
  logic [CW-1:0]        ph;
  logic [CW-1:0]        last_ph;

  assign last_ph = (CW'(1) << ratio_log2) - CW'(1);

  always_comb begin
    win[0] = {{(AW-W){in_data[W-1]}}, in_data};
    for (int k = 1; k < NTAPS; k++)
      win[k] = {{(AW-W){hist[k-1][W-1]}}, hist[k-1]};
  end

  // folded symmetric sum: one product per coefficient pair
  always_comb begin
    acc = AW'(coef(NTAPS / 2)) * win[NTAPS / 2];
    for (int k = 0; k < NTAPS / 2; k++)
      acc = acc + AW'(coef(k)) * (win[k] + win[NTAPS-1-k]);
  end

  assign shifted = acc >>> COEF_SHIFT;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ph       <= '0;
      out_en   <= 1'b0;
      out_data <= '0;
      for (int k = 0; k < NTAPS - 1; k++) hist[k] <= '0;
    end else begin
      out_en <= 1'b0;
      if (in_en) begin
        hist[0] <= in_data;
        for (int k = 1; k < NTAPS - 1; k++) hist[k] <= hist[k-1];
        if (ph == last_ph) begin
          ph       <= '0;
          out_en   <= 1'b1;
          out_data <= shifted[W-1:0];
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  // R4: a decimating stage never emits on back-to-back cycles
  p_out_spacing_r4: assert property (@(posedge clk) disable iff (rst)
    out_en |=> !out_en);

  // R5: phase counter never passes the selected ratio
  p_phase_range_r5: assert property (@(posedge clk) disable iff (rst)
    ph <= last_ph);

endmodule

// File: rtl/fill_timer.sv
module fill_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || load)               cnt <= load_val;
    else if (tick && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R9: the discard count moves only on an output word or a reload
  p_fill_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cnt));

endmodule

// File: rtl/decim_chain.sv
module decim_chain
  import decim_pkg::*;
#(
  parameter int W_IN           = 16,
  parameter int W_OUT          = 24,
  parameter int FILL_PER_STAGE = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_tap,
  input  logic                    cfg_s2_bypass,
  input  logic [2:0]              cfg_s2_sel,
  input  logic                    in_en,
  input  logic signed [W_IN-1:0]  in_data,
  output logic                    out_stb,
  output logic signed [W_OUT-1:0] out_data,
  output logic                    out_valid
);

  localparam int NST  = 3;
  localparam int LW   = 3;
  localparam int FCW  = $clog2(NST * FILL_PER_STAGE + 1);

  cfg_t cfg_q, cfg_next;

  always_comb begin
    cfg_next = rst ? CFG_DEFAULT
                   : '{tap: tap_e'(cfg_tap), s2_bypass: cfg_s2_bypass, s2_sel: cfg_s2_sel};
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= CFG_DEFAULT;
    else if (cfg_we) cfg_q <= cfg_next;
  end

  function automatic logic [FCW-1:0] preload(input cfg_t c);
    int s;
    case (c.tap)
      TAP_RAW: s = 0;
      TAP_S1:  s = 1;
      TAP_S2:  s = c.s2_bypass ? 1 : 2;
      default: s = c.s2_bypass ? 2 : 3;
    endcase
    return FCW'(s * FILL_PER_STAGE);
  endfunction

  // stage wiring
  logic [NST-1:0]         st_en_i, st_en_o;
  logic signed [W_IN-1:0] st_d_i [NST];
  logic signed [W_IN-1:0] st_d_o [NST];
  logic [LW-1:0]          st_lg  [NST];

  always_comb begin
    st_en_i[0] = in_en && (cfg_q.tap != TAP_RAW);
    st_d_i[0]  = in_data;
    st_lg[0]   = LW'(2);
    st_en_i[1] = st_en_o[0] && !cfg_q.s2_bypass && (cfg_q.tap >= TAP_S2);
    st_d_i[1]  = st_d_o[0];
    st_lg[1]   = s2_log2(cfg_q.s2_sel);
    st_en_i[2] = (cfg_q.s2_bypass ? st_en_o[0] : st_en_o[1]) && (cfg_q.tap == TAP_S3);
    st_d_i[2]  = cfg_q.s2_bypass ? st_d_o[0] : st_d_o[1];
    st_lg[2]   = LW'(1);
  end

  for (genvar g = 0; g < NST; g++) begin : g_stage
    fir_decim #(.W(W_IN), .LW(LW)) u_fir (
      .clk        (clk),
      .rst        (rst),
      .clr        (cfg_we),
      .in_en      (st_en_i[g]),
      .in_data    (st_d_i[g]),
      .ratio_log2 (st_lg[g]),
      .out_en     (st_en_o[g]),
      .out_data   (st_d_o[g])
    );
  end

  // tap selection
  logic                   sel_en;
  logic signed [W_IN-1:0] sel_d;

  always_comb begin
    case (cfg_q.tap)
      TAP_RAW: begin sel_en = in_en;      sel_d = in_data;   end
      TAP_S1:  begin sel_en = st_en_o[0]; sel_d = st_d_o[0]; end
      TAP_S2:  begin
        sel_en = cfg_q.s2_bypass ? st_en_o[0] : st_en_o[1];
        sel_d  = cfg_q.s2_bypass ? st_d_o[0]  : st_d_o[1];
      end
      default: begin sel_en = st_en_o[2]; sel_d = st_d_o[2]; end
    endcase
  end

  logic fill_done;

  fill_timer #(.CW(FCW)) u_fill (
    .clk      (clk),
    .rst      (rst),
    .load     (cfg_we),
    .load_val (preload(cfg_next)),
    .tick     (sel_en && !cfg_we),
    .done     (fill_done)
  );

  always_ff @(posedge clk) begin
    if (rst || cfg_we) begin
      out_stb   <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_stb <= sel_en;
      if (sel_en) begin
        out_data  <= W_OUT'(sel_d);
        out_valid <= fill_done;
      end
    end
  end

  logic signed [W_OUT-1:0] in_ext;
  assign in_ext = W_OUT'(in_data);

  // R1: reset leaves the output quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!out_stb && !out_valid));

  // R2: raw tap passes the sample through one cycle later
  p_raw_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.tap == TAP_RAW && in_en && !cfg_we) |=> (out_stb && out_data == $past(in_ext)));

  // R10: a configuration write flushes the output
  p_cfg_flush_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (!out_stb && !out_valid));

  // R9: valid is sticky until the next write
  p_valid_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !cfg_we) |=> out_valid);

  // R8: filtered output words are never adjacent
  p_filtered_gap_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.tap != TAP_RAW && out_stb) |=> !out_stb);

endmodule

// File: tb/decim_chain_tb.sv
module decim_chain_tb;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cfg_we = 1'b0;
  logic [1:0]         cfg_tap = 2'd0;
  logic               cfg_s2_bypass = 1'b0;
  logic [2:0]         cfg_s2_sel = 3'd0;
  logic               in_en = 1'b0;
  logic signed [15:0] in_data = '0;
  logic               out_stb;
  logic signed [23:0] out_data;
  logic               out_valid;

  always #10 clk = ~clk;

  decim_chain u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_tap(cfg_tap),
    .cfg_s2_bypass(cfg_s2_bypass), .cfg_s2_sel(cfg_s2_sel),
    .in_en(in_en), .in_data(in_data),
    .out_stb(out_stb), .out_data(out_data), .out_valid(out_valid)
  );

  typedef struct { int d; bit v; } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0;
  int n_in = 0, n_got = 0, w_idx = 0, fill_n = 12;
  int b_tap = 3, b_byp = 0, b_sel = 4;
  string reqtag = "R7";
  int m_hist[3][7];
  int m_ph[3];
  int CO[7] = '{1, 2, 3, 4, 3, 2, 1};

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int s2_ratio(input int sel);
    return (sel >= 4) ? 32 : (2 << sel);
  endfunction

  function automatic int prod();
    int r2;
    r2 = b_byp ? 1 : s2_ratio(b_sel);
    case (b_tap)
      0: return 1;
      1: return 4;
      2: return 4 * r2;
      default: return 8 * r2;
    endcase
  endfunction

  task automatic model_clear();
    for (int s = 0; s < 3; s++) begin
      m_ph[s] = 0;
      for (int k = 0; k < 7; k++) m_hist[s][k] = 0;
    end
  endtask

  task automatic m_stage(input int s, input int x, input int ratio, output bit emit, output int y);
    int acc;
    for (int k = 6; k > 0; k--) m_hist[s][k] = m_hist[s][k-1];
    m_hist[s][0] = x;
    m_ph[s]++;
    emit = 0;
    y = 0;
    if (m_ph[s] == ratio) begin
      m_ph[s] = 0;
      acc = 0;
      for (int k = 0; k < 7; k++) acc += CO[k] * m_hist[s][k];
      y = acc >>> 4;
      emit = 1;
    end
  endtask

  task automatic push(input int y);
    exp_t e;
    e.d = y;
    e.v = (w_idx >= fill_n);
    exp_q.push_back(e);
    w_idx++;
  endtask

  task automatic model_step(input int x);
    bit e1, e2, e3;
    int y1, y2, y3;
    if (b_tap == 0) begin push(x); return; end
    m_stage(0, x, 4, e1, y1);
    if (!e1) return;
    if (b_tap == 1) begin push(y1); return; end
    if (b_byp) begin e2 = 1; y2 = y1; end
    else m_stage(1, y1, s2_ratio(b_sel), e2, y2);
    if (!e2) return;
    if (b_tap == 2) begin push(y2); return; end
    m_stage(2, y2, 2, e3, y3);
    if (e3) push(y3);
  endtask

  // driver: called right after a falling edge
  task automatic feed(input int x);
    in_en = 1'b1;
    in_data = 16'(x);
    n_in++;
    model_step(x);
    @(negedge clk);
    in_en = 1'b0;
  endtask

  task automatic run(input int n, input int kind, input bit gaps);
    int x;
    for (int i = 0; i < n; i++) begin
      case (kind)
        0: x = int'($urandom_range(0, 65535)) - 32768;
        1: x = -32768;
        default: x = (i * 517) % 65536 - 32768;
      endcase
      feed(x);
      if (gaps) @(negedge clk);
    end
  endtask

  task automatic cfg_write(input int tap, input int byp, input int sel,
                           input bit with_sample, input int x);
    cfg_tap = 2'(tap);
    cfg_s2_bypass = byp[0];
    cfg_s2_sel = 3'(sel);
    cfg_we = 1'b1;
    in_en = with_sample;
    in_data = 16'(x);
    b_tap = tap; b_byp = byp; b_sel = sel;
    case (tap)
      0: fill_n = 0;
      1: fill_n = 4;
      2: fill_n = byp ? 4 : 8;
      default: fill_n = byp ? 8 : 12;
    endcase
    model_clear();
    exp_q.delete();
    n_in = 0; n_got = 0; w_idx = 0;
    reqtag = (tap == 0) ? "R2" : (tap == 1) ? "R4" : (tap == 2) ? (byp ? "R6" : "R5") : "R7";
    @(negedge clk);
    cfg_we = 1'b0;
    in_en = 1'b0;
    // R10: flushed output right after the write
    check(!out_stb && !out_valid, "R10", {30'd0, out_stb, out_valid}, 0);
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
    check(exp_q.size() == 0, "R8", exp_q.size(), 0);
    check(n_got == n_in / prod(), "R8", n_got, n_in / prod());
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (!rst && out_stb) begin
        n_got++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", int'(out_data), 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(int'(out_data) == e.d, reqtag, int'(out_data), e.d);
          check(out_valid == e.v, "R9", int'(out_valid), int'(e.v));
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    model_clear();
    repeat (5) @(negedge clk);
    check(!out_stb && !out_valid, "R1", {30'd0, out_stb, out_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_stb && !out_valid, "R1", {30'd0, out_stb, out_valid}, 0);

    // R1/R7: default configuration, full chain at ratio 32
    run(3584, 0, 1'b0);
    drain();

    // R2: raw tap
    cfg_write(0, 0, 0, 1'b0, 0);
    run(40, 0, 1'b0);
    drain();

    // R4: stage 1 with idle cycles between samples
    cfg_write(1, 0, 0, 1'b0, 0);
    run(120, 2, 1'b1);
    drain();

    // R5: stage 2 at ratios 2 and 16, and an out-of-range code
    cfg_write(2, 0, 0, 1'b0, 0);
    run(200, 0, 1'b0);
    drain();
    cfg_write(2, 0, 3, 1'b0, 0);
    run(960, 0, 1'b0);
    drain();
    cfg_write(2, 0, 6, 1'b0, 0);
    run(1536, 0, 1'b0);
    drain();

    // R6: stage 2 bypassed at tap 2
    cfg_write(2, 1, 2, 1'b0, 0);
    run(120, 0, 1'b0);
    drain();

    // R3/R6: full-scale negative input, stage 1 straight into stage 3
    cfg_write(3, 1, 0, 1'b0, 0);
    run(200, 1, 1'b0);
    drain();

    // R7: full chain at stage-2 ratio 4
    cfg_write(3, 0, 1, 1'b0, 0);
    run(800, 0, 1'b0);
    drain();

    // R10: write mid-stream with a sample in the same cycle
    cfg_write(3, 0, 2, 1'b0, 0);
    run(500, 0, 1'b0);
    cfg_write(1, 0, 0, 1'b1, 12345);
    run(100, 2, 1'b0);
    drain();

    summary();
    $finish;
  end

endmodule